// File: doc/BRIEF.md
# SPI Controller Register and Interrupt File

This block is the software-visible face of a small SPI controller. A simple bus with write strobe, read strobe, byte address, write data and read data reaches eleven word-aligned registers. They hold the controller configuration, the enable bit, the inter-transfer delay, the idle count and the TX watermark threshold. The block presents these values to the serial engine as plain outputs.

Interrupts use a seven-bit event layout. A status register latches events and is cleared by writing ones to it. A write-only set register and a write-only clear register build the mask, and a read-only view returns the mask. One level-sensitive interrupt output is high while any status bit is both pending and enabled.

Writes to the TX data offset and reads of the RX data offset become one-cycle push and pop strobes toward the FIFOs, which live outside this block together with the shift logic. Raw event lines come in from the FIFOs and the serial engine.

Top module: `spi_regfile`

## Requirements
- R1: After reset the status bits, the mask bits and the enable bit are 0, the interrupt output is low, and the TX threshold register reads 1.
- R2: A write to the mask-set register (byte offset 0x08) sets every mask bit written as 1. A write to the mask-clear register (0x0C) clears every mask bit written as 1. Bits written as 0 and bits above bit 6 leave the mask unchanged. The mask reads back at offset 0x10.
- R3: The status register at 0x04 is write-1-to-clear. Writing 1 to a latched edge bit (bits 0, 1, 5, 6; bit 1 is mode fault) clears it, and writing 0 leaves it set.
- R4: The level bits are bit 2 (TX below watermark), bit 3 (TX full) and bit 4 (RX not empty). Each is set one clock after its condition goes high. It ignores clear writes while the condition holds and can be cleared once the condition is low.
- R5: An edge bit is set only on a 0-to-1 transition of its event line. An event line held high does not set the bit again after it has been cleared.
- R6: The interrupt output is the OR over all bits of (status AND mask). It is low whenever the mask is zero.
- R7: A write to offset 0x1C gives a tx_push pulse in that bus cycle with the low 8 bits of the write data. A read of offset 0x20 gives an rx_pop pulse in that cycle and returns the FIFO byte on the read data. Accesses to other offsets produce neither strobe.
- R8: The enable register at 0x14 keeps only bit 0 (1 = enabled). The other bits read as 0.
- R9: The configuration (0x00, CFG_W bits), delay (0x18, 32 bits), idle count (0x24, IDLE_W bits) and threshold (0x28) registers read back what was written, truncated to their widths. Writing all ones to the threshold reads back FIFO_DEPTH-1.
- R10: A write to the read-only mask view at 0x10 has no effect on the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the strobe cycle |
| tx_push | output | 1 | One-cycle push toward the TX FIFO |
| tx_byte | output | 8 | Byte to push |
| rx_pop | output | 1 | One-cycle pop toward the RX FIFO |
| rx_byte | input | 8 | Head byte of the RX FIFO |
| ev_raw | input | 7 | Raw event lines in the interrupt layout |
| ctrl_cfg | output | CFG_W | Configuration value |
| ctrl_enable | output | 1 | Controller enable |
| ctrl_delay | output | DATA_W | Delay value |
| ctrl_idle | output | IDLE_W | Idle count value |
| ctrl_thresh | output | THR_W | TX watermark threshold |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a status bit whose event line stays high across a clear write. The edge and level classes must then part ways: an edge bit stays cleared, and a level bit refuses the clear. The bench holds the event line high over several cycles, writes the clear in between, and reads the status before and after the line is released. It then raises the line a second time to show that a fresh transition sets the edge bit again.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  localparam int NIRQ = 7;
  localparam int NREG = 11;

  typedef enum logic [3:0] {
    RG_CFG  = 4'd0,
    RG_ISR  = 4'd1,
    RG_IEN  = 4'd2,
    RG_IDIS = 4'd3,
    RG_IMSK = 4'd4,
    RG_ENA  = 4'd5,
    RG_DLY  = 4'd6,
    RG_TXD  = 4'd7,
    RG_RXD  = 4'd8,
    RG_IDLE = 4'd9,
    RG_THR  = 4'd10
  } reg_idx_e;

  // bits 2,3,4 follow a live condition; the rest latch on a rising edge
  localparam logic [NIRQ-1:0] LEVEL_MASK = 7'b0011100;
  localparam logic [NIRQ-1:0] EDGE_MASK  = ~LEVEL_MASK;

  function automatic logic [NIRQ-1:0] stat_next(input logic [NIRQ-1:0] stat,
                                                input logic [NIRQ-1:0] setv,
                                                input logic [NIRQ-1:0] clrv);
    return setv | (stat & ~clrv);
  endfunction

  function automatic logic [NIRQ-1:0] mask_next(input logic [NIRQ-1:0] mask,
                                                input logic [NIRQ-1:0] setv,
                                                input logic [NIRQ-1:0] clrv);
    return (mask | setv) & ~clrv;
  endfunction
endpackage

// File: rtl/spi_rf_decode.sv
module spi_rf_decode
  import spi_rf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic [NREG-1:0]   hit,
  output logic [NREG-1:0]   wsel,
  output logic              pop
);
  localparam int IDX_W = ADDR_W - 2;

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit[i] = (addr[ADDR_W-1:2] == IDX_W'(i)) && (addr[1:0] == 2'b00);
  end

  assign wsel = hit & {NREG{wr}};
  assign pop  = rd & hit[RG_RXD];
endmodule

// File: rtl/spi_rf_irq.sv
module spi_rf_irq
  import spi_rf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] ev_raw,
  input  logic            wr_isr,
  input  logic            wr_ien,
  input  logic            wr_idis,
  input  logic [NIRQ-1:0] wbits,
  output logic [NIRQ-1:0] stat_q,
  output logic [NIRQ-1:0] mask_q,
  output logic [NIRQ-1:0] rise_vec,
  output logic            irq
);
  logic [NIRQ-1:0] ev_q;
  logic [NIRQ-1:0] set_vec;
  logic [NIRQ-1:0] clr_vec;

  assign rise_vec = ev_raw & ~ev_q;

  for (genvar i = 0; i < NIRQ; i++) begin : g_src
    if (LEVEL_MASK[i]) begin : g_lvl
      assign set_vec[i] = ev_raw[i];
    end else begin : g_edge
      assign set_vec[i] = rise_vec[i];
    end
  end

  assign clr_vec = wr_isr ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q   <= '0;
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      ev_q   <= ev_raw;
      stat_q <= stat_next(stat_q, set_vec, clr_vec);
      mask_q <= mask_next(mask_q, wr_ien ? wbits : '0, wr_idis ? wbits : '0);
    end
  end

  assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/spi_rf_ctrl.sv
module spi_rf_ctrl #(
  parameter int DATA_W = 32,
  parameter int CFG_W  = 18,
  parameter int IDLE_W = 8,
  parameter int THR_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_cfg,
  input  logic              wr_ena,
  input  logic              wr_dly,
  input  logic              wr_idle,
  input  logic              wr_thr,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              ena_q,
  output logic [DATA_W-1:0] dly_q,
  output logic [IDLE_W-1:0] idle_q,
  output logic [THR_W-1:0]  thr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      ena_q  <= 1'b0;
      dly_q  <= '0;
      idle_q <= '0;
      thr_q  <= THR_W'(1);
    end else begin
      if (wr_cfg)  cfg_q  <= wdata[CFG_W-1:0];
      if (wr_ena)  ena_q  <= wdata[0];
      if (wr_dly)  dly_q  <= wdata;
      if (wr_idle) idle_q <= wdata[IDLE_W-1:0];
      if (wr_thr)  thr_q  <= wdata[THR_W-1:0];
    end
  end
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
  import spi_rf_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int CFG_W      = 18,
  parameter int IDLE_W     = 8,
  parameter int FIFO_DEPTH = 128,
  parameter int THR_W      = $clog2(FIFO_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tx_push,
  output logic [7:0]        tx_byte,
  output logic              rx_pop,
  input  logic [7:0]        rx_byte,
  input  logic [NIRQ-1:0]   ev_raw,
  output logic [CFG_W-1:0]  ctrl_cfg,
  output logic              ctrl_enable,
  output logic [DATA_W-1:0] ctrl_delay,
  output logic [IDLE_W-1:0] ctrl_idle,
  output logic [THR_W-1:0]  ctrl_thresh,
  output logic              irq
);
  logic [NREG-1:0] hit;
  logic [NREG-1:0] wsel;
  logic [NIRQ-1:0] stat_q;
  logic [NIRQ-1:0] mask_q;
  logic [NIRQ-1:0] rise_vec;

  spi_rf_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .wr   (bus_wr),
    .rd   (bus_rd),
    .hit  (hit),
    .wsel (wsel),
    .pop  (rx_pop)
  );

  spi_rf_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_raw   (ev_raw),
    .wr_isr   (wsel[RG_ISR]),
    .wr_ien   (wsel[RG_IEN]),
    .wr_idis  (wsel[RG_IDIS]),
    .wbits    (bus_wdata[NIRQ-1:0]),
    .stat_q   (stat_q),
    .mask_q   (mask_q),
    .rise_vec (rise_vec),
    .irq      (irq)
  );

  spi_rf_ctrl #(
    .DATA_W (DATA_W),
    .CFG_W  (CFG_W),
    .IDLE_W (IDLE_W),
    .THR_W  (THR_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wdata   (bus_wdata),
    .wr_cfg  (wsel[RG_CFG]),
    .wr_ena  (wsel[RG_ENA]),
    .wr_dly  (wsel[RG_DLY]),
    .wr_idle (wsel[RG_IDLE]),
    .wr_thr  (wsel[RG_THR]),
    .cfg_q   (ctrl_cfg),
    .ena_q   (ctrl_enable),
    .dly_q   (ctrl_delay),
    .idle_q  (ctrl_idle),
    .thr_q   (ctrl_thresh)
  );

  assign tx_push = wsel[RG_TXD];
  assign tx_byte = bus_wdata[7:0];

  always_comb begin
    bus_rdata = '0;
    if (hit[RG_CFG])  bus_rdata = DATA_W'(ctrl_cfg);
    if (hit[RG_ISR])  bus_rdata = DATA_W'(stat_q);
    if (hit[RG_IMSK]) bus_rdata = DATA_W'(mask_q);
    if (hit[RG_ENA])  bus_rdata = DATA_W'(ctrl_enable);
    if (hit[RG_DLY])  bus_rdata = ctrl_delay;
    if (hit[RG_RXD])  bus_rdata = DATA_W'(rx_byte);
    if (hit[RG_IDLE]) bus_rdata = DATA_W'(ctrl_idle);
    if (hit[RG_THR])  bus_rdata = DATA_W'(ctrl_thresh);
  end
endmodule

// File: rtl/spi_regfile_chk.sv
module spi_regfile_chk
  import spi_rf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NIRQ-1:0]   wbits,
  input logic              tx_push,
  input logic              rx_pop,
  input logic [NIRQ-1:0]   ev_raw,
  input logic [NIRQ-1:0]   stat_q,
  input logic [NIRQ-1:0]   mask_q,
  input logic [NIRQ-1:0]   rise_vec,
  input logic              irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic at_ien, at_idis, at_txd, at_rxd;
  assign at_ien  = (bus_addr == {IDX_W'(RG_IEN), 2'b00});
  assign at_idis = (bus_addr == {IDX_W'(RG_IDIS), 2'b00});
  assign at_txd  = (bus_addr == {IDX_W'(RG_TXD), 2'b00});
  assign at_rxd  = (bus_addr == {IDX_W'(RG_RXD), 2'b00});

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && at_ien) |=> ((mask_q & $past(wbits)) == $past(wbits))); // R2
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && at_idis) |=> ((mask_q & $past(wbits)) == '0)); // R2
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq); // R6
  AST_LEVEL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(ev_raw) & LEVEL_MASK) & ~stat_q) == '0)); // R4
  AST_EDGE_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & EDGE_MASK & ~$past(rise_vec)) == '0)); // R5
  AST_PUSH_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> (bus_wr && at_txd)); // R7
  AST_POP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> (bus_rd && at_rxd)); // R7
endmodule

bind spi_regfile spi_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .wbits    (bus_wdata[6:0]),
  .tx_push  (tx_push),
  .rx_pop   (rx_pop),
  .ev_raw   (ev_raw),
  .stat_q   (stat_q),
  .mask_q   (mask_q),
  .rise_vec (rise_vec),
  .irq      (irq)
);

// File: tb/spi_regfile_test.sv
module spi_regfile_test;
  localparam logic [7:0] A_CFG = 8'h00, A_ISR = 8'h04, A_IEN = 8'h08, A_IDIS = 8'h0C,
                         A_IMSK = 8'h10, A_ENA = 8'h14, A_DLY = 8'h18, A_TXD = 8'h1C,
                         A_RXD = 8'h20, A_IDLE = 8'h24, A_THR = 8'h28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_push, rx_pop, ctrl_enable, irq;
  logic [7:0]  tx_byte;
  logic [7:0]  rx_byte = '0;
  logic [6:0]  ev_raw = '0;
  logic [17:0] ctrl_cfg;
  logic [31:0] ctrl_delay;
  logic [7:0]  ctrl_idle;
  logic [6:0]  ctrl_thresh;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  spi_regfile uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_push(tx_push), .tx_byte(tx_byte),
    .rx_pop(rx_pop), .rx_byte(rx_byte), .ev_raw(ev_raw), .ctrl_cfg(ctrl_cfg),
    .ctrl_enable(ctrl_enable), .ctrl_delay(ctrl_delay), .ctrl_idle(ctrl_idle),
    .ctrl_thresh(ctrl_thresh), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset;
    check("R1 irq", {31'd0, irq}, 32'd0);
    expect_reg("R1 mask", A_IMSK, 32'd0);
    expect_reg("R1 status", A_ISR, 32'd0);
    expect_reg("R1 enable", A_ENA, 32'd0);
    expect_reg("R1 threshold", A_THR, 32'd1);
  endtask

  task automatic t_mask;
    wr(A_IEN, 32'h12);
    expect_reg("R2 set", A_IMSK, 32'h12);
    wr(A_IEN, 32'h04);
    expect_reg("R2 set keeps others", A_IMSK, 32'h16);
    wr(A_IDIS, 32'h02);
    expect_reg("R2 clear", A_IMSK, 32'h14);
    wr(A_IEN, 32'hFF80);
    expect_reg("R2 upper bits ignored", A_IMSK, 32'h14);
    wr(A_IMSK, 32'h7F);
    expect_reg("R10 mask view read-only", A_IMSK, 32'h14);
    wr(A_IDIS, 32'h7F);
    expect_reg("R2 clear all", A_IMSK, 32'h00);
  endtask

  task automatic t_edge;
    ev_raw[1] = 1'b1;
    @(negedge clk);
    expect_reg("R5 mode fault latched", A_ISR, 32'h02);
    wr(A_ISR, 32'h00);
    expect_reg("R3 zero write keeps", A_ISR, 32'h02);
    wr(A_ISR, 32'h02);
    expect_reg("R3 W1C clears", A_ISR, 32'h00);
    repeat (3) @(negedge clk);
    expect_reg("R5 held line no reset", A_ISR, 32'h00);
    ev_raw[1] = 1'b0;
    @(negedge clk);
    ev_raw[1] = 1'b1; ev_raw[6] = 1'b1; ev_raw[0] = 1'b1;
    @(negedge clk);
    ev_raw = '0;
    expect_reg("R5 new rise sets", A_ISR, 32'h43);
    wr(A_ISR, 32'h41);
    expect_reg("R3 partial clear", A_ISR, 32'h02);
    wr(A_ISR, 32'h7F);
    expect_reg("R3 clear all", A_ISR, 32'h00);
  endtask

  task automatic t_level;
    ev_raw[4] = 1'b1;
    @(negedge clk);
    expect_reg("R4 level set", A_ISR, 32'h10);
    wr(A_ISR, 32'h10);
    expect_reg("R4 clear ignored while held", A_ISR, 32'h10);
    ev_raw[4] = 1'b0;
    @(negedge clk);
    wr(A_ISR, 32'h10);
    expect_reg("R4 clear after release", A_ISR, 32'h00);
  endtask

  task automatic t_irq;
    ev_raw[1] = 1'b1;
    @(negedge clk);
    ev_raw[1] = 1'b0;
    @(negedge clk);
    check("R6 masked pending no irq", {31'd0, irq}, 32'd0);
    wr(A_IEN, 32'h02);
    check("R6 irq on enable", {31'd0, irq}, 32'd1);
    wr(A_IDIS, 32'h02);
    check("R6 irq off on disable", {31'd0, irq}, 32'd0);
    wr(A_IEN, 32'h0A);
    check("R6 irq re-enabled", {31'd0, irq}, 32'd1);
    wr(A_ISR, 32'h02);
    check("R6 irq off on clear", {31'd0, irq}, 32'd0);
    ev_raw[3] = 1'b1;
    @(negedge clk);
    check("R6 level bit irq", {31'd0, irq}, 32'd1);
    ev_raw[3] = 1'b0;
    @(negedge clk);
    wr(A_ISR, 32'h08);
    check("R6 level irq gone", {31'd0, irq}, 32'd0);
    wr(A_IDIS, 32'h7F);
  endtask

  task automatic t_fifo;
    logic [31:0] v;
    bus_wr = 1'b1; bus_addr = A_TXD; bus_wdata = 32'h1A5;
    #1;
    check("R7 push strobe", {31'd0, tx_push}, 32'd1);
    check("R7 push byte", {24'd0, tx_byte}, 32'hA5);
    check("R7 no pop on write", {31'd0, rx_pop}, 32'd0);
    @(negedge clk);
    bus_wr = 1'b0;
    #1 check("R7 push one cycle", {31'd0, tx_push}, 32'd0);
    @(negedge clk);
    rx_byte = 8'h3C;
    bus_rd = 1'b1; bus_addr = A_RXD;
    #1;
    check("R7 pop strobe", {31'd0, rx_pop}, 32'd1);
    check("R7 pop data", bus_rdata, 32'h3C);
    @(negedge clk);
    bus_rd = 1'b0;
    #1 check("R7 pop one cycle", {31'd0, rx_pop}, 32'd0);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = A_DLY;
    #1 check("R7 no pop elsewhere", {31'd0, rx_pop}, 32'd0);
    @(negedge clk);
    bus_rd = 1'b0;
    rd(A_TXD, v);
    check("R7 tx offset reads zero", v, 32'd0);
  endtask

  task automatic t_ctrl;
    wr(A_ENA, 32'hFFFF_FFFF);
    expect_reg("R8 enable bit only", A_ENA, 32'd1);
    check("R8 enable output", {31'd0, ctrl_enable}, 32'd1);
    wr(A_ENA, 32'hFFFF_FFFE);
    expect_reg("R8 disable", A_ENA, 32'd0);
    wr(A_CFG, 32'hFFFF_FFFF);
    expect_reg("R9 cfg width", A_CFG, 32'h3_FFFF);
    check("R9 cfg output", {14'd0, ctrl_cfg}, 32'h3_FFFF);
    wr(A_DLY, 32'hDEAD_BEEF);
    expect_reg("R9 delay", A_DLY, 32'hDEAD_BEEF);
    wr(A_IDLE, 32'h1FF);
    expect_reg("R9 idle width", A_IDLE, 32'hFF);
    wr(A_THR, 32'hFFFF);
    expect_reg("R9 threshold depth-1", A_THR, 32'd127);
    check("R9 threshold output", {25'd0, ctrl_thresh}, 32'd127);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_edge();
    t_level();
    t_irq();
    t_fifo();
    t_ctrl();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule